// File: doc/BRIEF.md
# D-PHY High-Speed Entry Sequencer

This block runs on the byte clock and moves a serial display link from low-power mode into high-speed mode and back again. A video timing engine raises a request level. The sequencer first asks the clock lane to enter high-speed mode and waits a programmed wake-up count. It then holds the data lanes idle for a programmed guard interval. Next it asks every data lane to enter high-speed mode and waits a second programmed count. Only after that does it signal ready to the requester.

When the request drops, every lane request is withdrawn together. The sequencer then enforces a minimum low-power period before it serves a new request. A request that arrives during that period is remembered and served as soon as the period ends. All cycle counts are input ports, so one build can serve any bit rate. When the clock lane runs continuously, its wake-up wait shrinks to a single cycle.

Top module: `dphy_hs_sequencer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every output (`clk_lane_req`, `clk_lane_rdy`, `data_lane_req`, `data_lane_rdy`, `hs_ready`) is 0.
- R2: With the sequencer idle, `clk_lane_req` goes high at the first clock edge that samples `hs_req` high. At that edge `clk_lane_rdy` and `data_lane_req` are still 0.
- R3: With `cont_clk` low, `clk_lane_rdy` rises exactly `clk_wake_cyc` cycles after `clk_lane_req` rises.
- R4: With `cont_clk` high, `clk_lane_rdy` rises exactly 1 cycle after `clk_lane_req` rises, whatever `clk_wake_cyc` holds.
- R5: `data_lane_req` rises exactly `clk_pre_cyc` cycles after `clk_lane_rdy` rises, never while `clk_lane_rdy` is low. Every bit of `data_lane_req` rises at the same edge.
- R6: `hs_ready` and every bit of `data_lane_rdy` rise together, exactly `data_wake_cyc` cycles after `data_lane_req` rises.
- R7: While `hs_req` stays high in high-speed mode, all requests and ready outputs stay high. The first edge that samples `hs_req` low drives all of them to 0.
- R8: After a return to low-power mode, a held-high `hs_req` is not served early. `clk_lane_req` rises again exactly `lp_exit_cyc` cycles after it fell.
- R9: A one-cycle `hs_req` pulse during the low-power exit period is remembered. It is served at the end of that period, with the same timing as in R8.
- R10: A programmed count of 0 in any of `clk_wake_cyc`, `clk_pre_cyc`, `data_wake_cyc` or `lp_exit_cyc` behaves as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_req | input | 1 | Level request for high-speed mode from the timing engine |
| cont_clk | input | 1 | Clock lane runs continuously; wake-up costs 1 cycle |
| clk_wake_cyc | input | CW | Clock-lane wake-up count in cycles |
| clk_pre_cyc | input | CW | Guard interval between clock-lane ready and data-lane request |
| data_wake_cyc | input | CW | Data-lane wake-up count in cycles |
| lp_exit_cyc | input | CW | Minimum low-power period after high-speed mode ends |
| clk_lane_req | output | 1 | Clock lane high-speed request |
| clk_lane_rdy | output | 1 | Clock lane reported ready |
| data_lane_req | output | NUM_DL | Data lane high-speed requests |
| data_lane_rdy | output | NUM_DL | Data lanes reported ready |
| hs_ready | output | 1 | Link ready for high-speed traffic |

## Verification
Each output is a register loaded from the next-state decode. A request sampled at edge E therefore shows `clk_lane_req` right after E. Clock-lane ready follows the wake count in cycles later, data requests follow the guard count after that, and `hs_ready` follows the data count after that. The exit phase follows the same pattern with the exit count.

The bench drives inputs and samples outputs on falling edges. It counts falling edges from the first observation of one rise to the first observation of the next. That difference equals the programmed count exactly, with no slack. Each drop or rise that must happen at a given edge is checked on the very next falling edge.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;
  typedef enum logic [2:0] {
    IDLE_LP   = 3'd0,
    CLK_WAKE  = 3'd1,
    CLK_PRE   = 3'd2,
    DATA_WAKE = 3'd3,
    HS_ACTIVE = 3'd4,
    LP_EXIT   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/dphy_seq_counter.sv
// Shared phase timer: a load of N makes zero assert after N-1 decrements,
// so a phase lasts N cycles; a load of 0 is clamped to a 1-cycle phase.
module dphy_seq_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
    end else if (dec && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dphy_seq_lane_out.sv
// Registered lane outputs decoded from the next state, so they change on
// the same edge as the state register.
module dphy_seq_lane_out
  import dphy_seq_pkg::*;
#(
  parameter int NUM_DL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        nxt_state,
  output logic              clk_lane_req,
  output logic              clk_lane_rdy,
  output logic [NUM_DL-1:0] data_lane_req,
  output logic [NUM_DL-1:0] data_lane_rdy,
  output logic              hs_ready
);
  logic cl_req_d, cl_rdy_d, dl_req_d, hs_d;

  always_comb begin
    cl_req_d = nxt_state inside {CLK_WAKE, CLK_PRE, DATA_WAKE, HS_ACTIVE};
    cl_rdy_d = nxt_state inside {CLK_PRE, DATA_WAKE, HS_ACTIVE};
    dl_req_d = nxt_state inside {DATA_WAKE, HS_ACTIVE};
    hs_d     = (nxt_state == HS_ACTIVE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_lane_req <= 1'b0;
      clk_lane_rdy <= 1'b0;
      hs_ready     <= 1'b0;
    end else begin
      clk_lane_req <= cl_req_d;
      clk_lane_rdy <= cl_rdy_d;
      hs_ready     <= hs_d;
    end
  end

  for (genvar g = 0; g < NUM_DL; g++) begin : g_dl
    always_ff @(posedge clk) begin
      if (rst) begin
        data_lane_req[g] <= 1'b0;
        data_lane_rdy[g] <= 1'b0;
      end else begin
        data_lane_req[g] <= dl_req_d;
        data_lane_rdy[g] <= hs_d;
      end
    end
  end
endmodule

// File: rtl/dphy_hs_sequencer.sv
module dphy_hs_sequencer
  import dphy_seq_pkg::*;
#(
  parameter int NUM_DL = 2,
  parameter int CW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_req,
  input  logic              cont_clk,
  input  logic [CW-1:0]     clk_wake_cyc,
  input  logic [CW-1:0]     clk_pre_cyc,
  input  logic [CW-1:0]     data_wake_cyc,
  input  logic [CW-1:0]     lp_exit_cyc,
  output logic              clk_lane_req,
  output logic              clk_lane_rdy,
  output logic [NUM_DL-1:0] data_lane_req,
  output logic [NUM_DL-1:0] data_lane_rdy,
  output logic              hs_ready
);
  localparam logic [CW-1:0] ONE_CYC = CW'(1);

  seq_state_e    state_q, nxt_state;
  logic          pend_q;
  logic          t_load, t_dec, t_zero;
  logic [CW-1:0] t_val, wake_val;

  assign wake_val = cont_clk ? ONE_CYC : clk_wake_cyc;

  always_comb begin
    nxt_state = state_q;
    t_load    = 1'b0;
    t_dec     = 1'b0;
    t_val     = '0;
    unique case (state_q)
      IDLE_LP: if (hs_req) begin
        nxt_state = CLK_WAKE; t_load = 1'b1; t_val = wake_val;
      end
      CLK_WAKE: if (t_zero) begin
        nxt_state = CLK_PRE; t_load = 1'b1; t_val = clk_pre_cyc;
      end else t_dec = 1'b1;
      CLK_PRE: if (t_zero) begin
        nxt_state = DATA_WAKE; t_load = 1'b1; t_val = data_wake_cyc;
      end else t_dec = 1'b1;
      DATA_WAKE: if (t_zero) nxt_state = HS_ACTIVE;
      else t_dec = 1'b1;
      HS_ACTIVE: if (!hs_req) begin
        nxt_state = LP_EXIT; t_load = 1'b1; t_val = lp_exit_cyc;
      end
      LP_EXIT: if (t_zero) begin
        if (pend_q || hs_req) begin
          nxt_state = CLK_WAKE; t_load = 1'b1; t_val = wake_val;
        end else nxt_state = IDLE_LP;
      end else t_dec = 1'b1;
      default: nxt_state = IDLE_LP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= IDLE_LP;
      pend_q  <= 1'b0;
    end else begin
      state_q <= nxt_state;
      pend_q  <= (state_q == LP_EXIT) && (nxt_state == LP_EXIT) && (pend_q || hs_req);
    end
  end

  dphy_seq_counter #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
    .dec(t_dec), .zero(t_zero)
  );

  dphy_seq_lane_out #(.NUM_DL(NUM_DL)) u_out (
    .clk(clk), .rst(rst), .nxt_state(nxt_state),
    .clk_lane_req(clk_lane_req), .clk_lane_rdy(clk_lane_rdy),
    .data_lane_req(data_lane_req), .data_lane_rdy(data_lane_rdy),
    .hs_ready(hs_ready)
  );

  // R5
  data_after_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_lane_req[0]) |-> $past(clk_lane_rdy));

  // R6
  ready_after_data_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_ready) |-> $past(data_lane_req[0]));

  // R9
  pending_served_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LP_EXIT && t_zero && pend_q) |=> (state_q == CLK_WAKE));

  // R8
  exit_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LP_EXIT) |-> !clk_lane_req);
endmodule

// File: tb/dphy_hs_sequencer_tb.sv
module dphy_hs_sequencer_tb_top;
  localparam int NUM_DL = 2;
  localparam int CW     = 8;

  logic clk = 1'b0, rst = 1'b1, hs_req = 1'b0, cont_clk = 1'b0;
  logic [CW-1:0] clk_wake_cyc = 8'd36, clk_pre_cyc = 8'd4;
  logic [CW-1:0] data_wake_cyc = 8'd18, lp_exit_cyc = 8'd8;
  logic clk_lane_req, clk_lane_rdy, hs_ready;
  logic [NUM_DL-1:0] data_lane_req, data_lane_rdy;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dphy_hs_sequencer #(.NUM_DL(NUM_DL), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .hs_req(hs_req), .cont_clk(cont_clk),
    .clk_wake_cyc(clk_wake_cyc), .clk_pre_cyc(clk_pre_cyc),
    .data_wake_cyc(data_wake_cyc), .lp_exit_cyc(lp_exit_cyc),
    .clk_lane_req(clk_lane_req), .clk_lane_rdy(clk_lane_rdy),
    .data_lane_req(data_lane_req), .data_lane_rdy(data_lane_rdy),
    .hs_ready(hs_ready)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs_packed();
    return {27'd0, clk_lane_req, clk_lane_rdy, &data_lane_req, &data_lane_rdy, hs_ready};
  endfunction

  function automatic logic sig(input int s);
    case (s)
      0: return clk_lane_req;
      1: return clk_lane_rdy;
      2: return data_lane_req[0];
      default: return hs_ready;
    endcase
  endfunction

  // counts falling edges until the chosen output is seen high
  task automatic wait_rise(input int s, output int n);
    n = 0;
    while (!sig(s) && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; hs_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(outs_packed(), 0, "R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    chk(outs_packed(), 0, "R1 after reset");
  endtask

  // full entry; ends at a falling edge with hs_ready seen high
  task automatic t_enter(input logic cc, input int cw, input int pre, input int dw,
                         input int exp_cw, input int exp_pre, input int exp_dw,
                         input string tag);
    int n;
    do_reset();
    cont_clk = cc; clk_wake_cyc = CW'(cw); clk_pre_cyc = CW'(pre);
    data_wake_cyc = CW'(dw);
    hs_req = 1'b1;
    @(negedge clk);
    chk(clk_lane_req, 1, {"R2 req ", tag});
    chk(clk_lane_rdy | data_lane_req[0], 0, {"R2 no early ready ", tag});
    wait_rise(1, n);
    chk(n, exp_cw, cc ? {"R4 clk wake ", tag} : {"R3 clk wake ", tag});
    chk(data_lane_req[0], exp_pre == 0 ? 1 : 0, {"R5 data idle at clk ready ", tag});
    wait_rise(2, n);
    chk(n, exp_pre, {"R5 clk pre ", tag});
    chk(int'(data_lane_req), (1 << NUM_DL) - 1, {"R5 lanes together ", tag});
    wait_rise(3, n);
    chk(n, exp_dw, {"R6 data wake ", tag});
    chk(int'(data_lane_rdy), (1 << NUM_DL) - 1, {"R6 lanes ready ", tag});
  endtask

  task automatic t_hold_drop(input string tag);
    repeat (5) @(negedge clk);
    chk(outs_packed(), 31, {"R7 held ", tag});
    hs_req = 1'b0;
    @(negedge clk);
    chk(outs_packed(), 0, {"R7 dropped ", tag});
  endtask

  // hold_mode 1: request held high; 0: one-cycle pulse
  task automatic t_exit(input int l, input int exp_l, input logic held, input string req);
    int n;
    t_enter(1'b0, 3, 2, 3, 3, 2, 3, req);
    lp_exit_cyc = CW'(l);
    t_hold_drop(req);
    hs_req = 1'b1;
    if (!held) begin
      @(negedge clk);
      hs_req = 1'b0;
      chk(clk_lane_req, exp_l <= 1 ? 1 : 0, {req, " not early"});
      n = 1;
      if (!clk_lane_req) begin
        int m;
        wait_rise(0, m);
        n = n + m;
      end
    end else begin
      wait_rise(0, n);
    end
    chk(n, exp_l, {req, " exit length"});
    hs_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_enter(1'b0, 36, 4, 18, 36, 4, 18, "nominal");
    t_hold_drop("nominal");
    t_enter(1'b1, 36, 2, 20, 1, 2, 20, "continuous");
    t_hold_drop("continuous");
    t_enter(1'b0, 5, 1, 1, 5, 1, 1, "short");
    t_enter(1'b0, 0, 0, 0, 1, 1, 1, "R10 zero counts");
    t_hold_drop("R10");
    t_exit(8, 8, 1'b1, "R8");
    t_exit(5, 5, 1'b0, "R9");
    t_exit(0, 1, 1'b1, "R10 exit");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule